// File: doc/BRIEF.md
# Leveled Round-Robin Bus Requestor Arbiter

This block picks one of four internal requestors for a single bus master port and holds that grant until the requestor reports completion. An 8-bit level field gives each requestor a 2-bit weight. With the field cleared, every requestor is equal and a rotating pointer shares the port in strict turn. With any bit set, the highest weight among the active requestors wins. Ties are broken by the same rotating pointer.

A second output asks the bulk DMA requestor (source 3) to finish quickly. It fires while that requestor owns the port and another enabled party is waiting. The parties that can be enabled are two other requestors and a separate status-wait input. That input does not request the port itself. Decisions and the hurry flag are both registered, so every output changes only on a clock edge.

Top module: `prio_arb_top`

## Requirements
- R1: Synchronous active-high reset clears `gnt_o` and `hurry_o` and sets the rotating pointer to source 3. The tie order after reset is therefore 3, 0, 1, 2.
- R2: When no grant is held and at least one `req_i` bit is set at a clock edge, `gnt_o` shows exactly one set bit after that edge, and the set bit belongs to a requesting source.
- R3: A grant stays unchanged while `done_i` is low. A `done_i` pulse clears it at the next edge. The next grant can appear no earlier than the edge after that, even if requests stay high.
- R4: With `lvl_cfg_i` all zero, grants rotate. After source k is granted, the search starts at source (k+1) mod 4 and takes the first requester found in ascending order with wrap.
- R5: With `lvl_cfg_i` nonzero, source i has level `lvl_cfg_i[2i+1:2i]` (0 to 3). Among requesters, the numerically highest level wins.
- R6: Among requesters that share the top level, the rotating pointer of R4 picks the winner. The pointer advances past every granted source in both modes.
- R7: `hurry_o` rises one edge after source 3 holds the grant while an enabled waiter is present, and falls one edge after that stops. `hurry_en_i[0]` enables `stat_wait_i`, `hurry_en_i[1]` enables `req_i[1]`, and `hurry_en_i[2]` enables `req_i[2]`.
- R8: `stat_wait_i` never produces a grant. A waiter whose enable bit is clear never raises `hurry_o`, and no waiter raises it while source 3 does not hold the grant.
- R9: A `done_i` pulse while no grant is held has no effect on grants or on the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Request per source (3 bulk DMA, 2 core, 1 receive queue, 0 interrupt status) |
| done_i | input | 1 | Current grant holder has finished |
| lvl_cfg_i | input | 8 | Two-bit level per source, source i at bits 2i+1:2i |
| hurry_en_i | input | 3 | Hurry enables: bit0 status wait, bit1 source 1, bit2 source 2 |
| stat_wait_i | input | 1 | Status-wait indication, not an arbitration request |
| gnt_o | output | 4 | One-hot registered grant |
| hurry_o | output | 1 | Registered hurry request to source 3 |

## Verification
The hardest situation to reach is a waiting source sitting behind source 3's grant while the pointer and levels are in a known state. The stimulus first walks the pointer to a position from which source 3 is the only requester. It then withholds `done_i` so the grant stays put. While the grant is held, it raises and drops the other requests, the status-wait input and the enable bits one at a time, checking the hurry flag one edge after each change.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  // Source roles, index equals position in req/gnt vectors
  typedef enum logic [1:0] {
    SRC_IRQ  = 2'd0,
    SRC_RXQ  = 2'd1,
    SRC_CORE = 2'd2,
    SRC_DMA  = 2'd3
  } src_e;

  // Bit positions of the hurry enable vector
  localparam int unsigned HEN_STAT = 0;
  localparam int unsigned HEN_RXQ  = 1;
  localparam int unsigned HEN_CORE = 2;
  localparam int unsigned HEN_W    = 3;
endpackage

// File: rtl/prio_arb_pick.sv
module prio_arb_pick #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned LVL_W = 2,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_SRC-1:0]         req,
  input  logic [N_SRC*LVL_W-1:0]   lvl_flat,
  input  logic [IDX_W-1:0]         ptr,
  output logic                     any_o,
  output logic [IDX_W-1:0]         win_o
);
  logic [LVL_W-1:0] best_lvl;
  logic [LVL_W-1:0] max_lvl;
  logic             found;

  // Scan in pointer order; strict greater-than keeps the earliest on a tie
  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    win_o    = '0;
    for (int k = 0; k < int'(N_SRC); k++) begin
      int idx;
      idx = (int'(ptr) + k) % int'(N_SRC);
      if (req[idx] && (!found || lvl_flat[idx*LVL_W +: LVL_W] > best_lvl)) begin
        found    = 1'b1;
        best_lvl = lvl_flat[idx*LVL_W +: LVL_W];
        win_o    = IDX_W'(idx);
      end
    end
    any_o = found;
  end

  // Independent maximum over all requesters, order-free
  always_comb begin
    max_lvl = '0;
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (req[i] && lvl_flat[i*LVL_W +: LVL_W] > max_lvl)
        max_lvl = lvl_flat[i*LVL_W +: LVL_W];
    end
  end

  // R5: the chosen source carries the top level and is requesting
  assert_win_top_level_R5: assert property (@(posedge clk) disable iff (rst)
    any_o |-> (req[win_o] && lvl_flat[win_o*LVL_W +: LVL_W] == max_lvl));

  // R2: a winner exists whenever anyone requests
  assert_pick_found_R2: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> any_o);
endmodule

// File: rtl/prio_arb_grant.sv
module prio_arb_grant #(
  parameter int unsigned N_SRC     = 4,
  parameter int unsigned RESET_PTR = 3,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               any,
  input  logic [IDX_W-1:0]   win,
  input  logic               done,
  output logic [N_SRC-1:0]   gnt_o,
  output logic [IDX_W-1:0]   ptr_o
);
  logic [N_SRC-1:0] gnt_q;
  logic [IDX_W-1:0] ptr_q;
  logic             busy;

  assign busy = |gnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q <= '0;
      ptr_q <= IDX_W'(RESET_PTR);
    end else if (busy) begin
      if (done) gnt_q <= '0;
    end else if (any) begin
      gnt_q      <= '0;
      gnt_q[win] <= 1'b1;
      ptr_q      <= (int'(win) == int'(N_SRC) - 1) ? '0 : win + 1'b1;
    end
  end

  assign gnt_o = gnt_q;
  assign ptr_o = ptr_q;

  // R2: never more than one owner
  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q));

  // R3: grant held while done is low
  assert_gnt_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(gnt_q));

  // R3: done releases the grant at the next edge
  assert_gnt_release_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && done) |=> (gnt_q == '0));

  // R9: done with no grant and no request leaves the pointer alone
  assert_idle_done_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !any) |=> ($stable(ptr_q) && gnt_q == '0));
endmodule

// File: rtl/prio_arb_hurry.sv
module prio_arb_hurry
  import prio_arb_pkg::*;
#(
  parameter int unsigned N_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   gnt,
  input  logic [N_SRC-1:0]   req,
  input  logic [HEN_W-1:0]   en,
  input  logic               stat_wait,
  output logic               hurry_o
);
  logic waiter;
  logic hurry_q;

  assign waiter = (en[HEN_STAT] & stat_wait)
                | (en[HEN_RXQ]  & req[SRC_RXQ])
                | (en[HEN_CORE] & req[SRC_CORE]);

  always_ff @(posedge clk) begin
    if (rst) hurry_q <= 1'b0;
    else     hurry_q <= gnt[SRC_DMA] & waiter;
  end

  assign hurry_o = hurry_q;

  // R8: no hurry unless the DMA source held the grant on the prior edge
  assert_hurry_needs_owner_R8: assert property (@(posedge clk) disable iff (rst)
    !gnt[SRC_DMA] |=> !hurry_q);

  // R8: with every enable clear the flag stays low
  assert_hurry_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !hurry_q);
endmodule

// File: rtl/prio_arb_top.sv
module prio_arb_top
  import prio_arb_pkg::*;
#(
  parameter int unsigned N_SRC     = 4,
  parameter int unsigned LVL_W     = 2,
  parameter int unsigned RESET_PTR = 3,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC-1:0]       req_i,
  input  logic                   done_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_cfg_i,
  input  logic [HEN_W-1:0]       hurry_en_i,
  input  logic                   stat_wait_i,
  output logic [N_SRC-1:0]       gnt_o,
  output logic                   hurry_o
);
  logic             any;
  logic [IDX_W-1:0] win;
  logic [IDX_W-1:0] ptr;

  prio_arb_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W)) pick_i (
    .clk(clk), .rst(rst), .req(req_i), .lvl_flat(lvl_cfg_i),
    .ptr(ptr), .any_o(any), .win_o(win)
  );

  prio_arb_grant #(.N_SRC(N_SRC), .RESET_PTR(RESET_PTR)) grant_i (
    .clk(clk), .rst(rst), .any(any), .win(win), .done(done_i),
    .gnt_o(gnt_o), .ptr_o(ptr)
  );

  prio_arb_hurry #(.N_SRC(N_SRC)) hurry_i (
    .clk(clk), .rst(rst), .gnt(gnt_o), .req(req_i), .en(hurry_en_i),
    .stat_wait(stat_wait_i), .hurry_o(hurry_o)
  );

  // R2: an idle port with a request is granted at the next edge
  assert_grant_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (gnt_o == '0 && req_i != '0) |=> (gnt_o != '0));

  // R8: with no request the status-wait input cannot create a grant
  assert_stat_no_grant_R8: assert property (@(posedge clk) disable iff (rst)
    (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0));
endmodule

// File: tb/prio_arb_top_tb_top.sv
module prio_arb_top_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] req;
  logic       done;
  logic [7:0] lvl;
  logic [2:0] hen;
  logic       swait;
  logic [3:0] gnt;
  logic       hurry;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  prio_arb_top dut_i (
    .clk(clk), .rst(rst), .req_i(req), .done_i(done), .lvl_cfg_i(lvl),
    .hurry_en_i(hen), .stat_wait_i(swait), .gnt_o(gnt), .hurry_o(hurry)
  );

  task automatic chk4(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk1(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // One full grant cycle: request, check winner, release, check idle
  task automatic arb_round(input logic [3:0] r, input logic [7:0] lv,
                           input int exp, input string tag);
    @(negedge clk);
    req = r; lvl = lv;
    @(negedge clk);
    chk4(gnt, 4'(1 << exp), tag);
    done = 1'b1; req = 4'b0;
    @(negedge clk);
    done = 1'b0;
    chk4(gnt, 4'b0, {tag, " R3 release"});
  endtask

  task automatic t_reset();
    rst = 1'b1; req = '0; done = 1'b0; lvl = '0; hen = '0; swait = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk4(gnt, 4'b0, "R1 grant after reset");
    chk1(hurry, 1'b0, "R1 hurry after reset");
  endtask

  task automatic t_round_robin();
    arb_round(4'hF, 8'h00, 3, "R1 first winner is source 3");
    arb_round(4'hF, 8'h00, 0, "R4 rotate to 0");
    arb_round(4'hF, 8'h00, 1, "R4 rotate to 1");
    arb_round(4'hF, 8'h00, 2, "R4 rotate to 2");
    arb_round(4'b0101, 8'h00, 0, "R4 wrap skips idle 3");
    arb_round(4'b0101, 8'h00, 2, "R4 sparse requests");
  endtask

  task automatic t_levels();
    arb_round(4'hF, 8'h03, 0, "R5 source0 level3 wins");
    arb_round(4'hF, 8'h28, 1, "R6 tie 1/2 pick 1");
    arb_round(4'hF, 8'h28, 2, "R6 tie 1/2 pick 2");
    arb_round(4'hF, 8'h28, 1, "R6 tie wraps to 1");
    arb_round(4'b1001, 8'h42, 0, "R5 level2 beats level1");
    arb_round(4'hF, 8'hC0, 3, "R5 source3 level3 wins");
    arb_round(4'hF, 8'h55, 0, "R6 uniform nonzero rotates");
  endtask

  task automatic t_hold_release();
    @(negedge clk);
    req = 4'b0011; lvl = 8'h00;
    @(negedge clk);
    chk4(gnt, 4'b0010, "R3 initial grant 1");
    repeat (3) begin
      @(negedge clk);
      chk4(gnt, 4'b0010, "R3 grant held");
    end
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk4(gnt, 4'b0000, "R3 idle cycle with requests high");
    @(negedge clk);
    chk4(gnt, 4'b0001, "R3 next grant to 0");
    done = 1'b1; req = 4'b0;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic t_idle_done();
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk4(gnt, 4'b0000, "R9 stray done no grant");
    arb_round(4'hF, 8'h00, 1, "R9 pointer unchanged");
  endtask

  task automatic t_hurry();
    @(negedge clk);
    req = 4'b1000; lvl = 8'h00;
    @(negedge clk);
    chk4(gnt, 4'b1000, "R7 source3 owns port");
    req = 4'b1010; hen = 3'b000; swait = 1'b1;
    @(negedge clk);
    chk1(hurry, 1'b0, "R8 disabled waiters ignored");
    hen = 3'b010;
    @(negedge clk);
    chk1(hurry, 1'b1, "R7 source1 waiting enabled");
    hen = 3'b000;
    @(negedge clk);
    chk1(hurry, 1'b0, "R7 falls one edge later");
    req = 4'b1000; hen = 3'b001;
    @(negedge clk);
    chk1(hurry, 1'b1, "R7 status wait enabled");
    swait = 1'b0;
    @(negedge clk);
    chk1(hurry, 1'b0, "R7 status wait cleared");
    req = 4'b1100; hen = 3'b100;
    @(negedge clk);
    chk1(hurry, 1'b1, "R7 source2 waiting enabled");
    chk4(gnt, 4'b1000, "R3 grant held during hurry");
    done = 1'b1; req = 4'b0; hen = 3'b000;
    @(negedge clk);
    done = 1'b0;
    @(negedge clk);
    req = 4'b0100;
    @(negedge clk);
    chk4(gnt, 4'b0100, "R4 grant source 2");
    req = 4'b0110; hen = 3'b111; swait = 1'b1;
    @(negedge clk);
    chk1(hurry, 1'b0, "R8 no hurry when source3 not owner");
    done = 1'b1; req = 4'b0; hen = 3'b000;
    @(negedge clk);
    done = 1'b0;
    repeat (2) @(negedge clk);
    chk4(gnt, 4'b0000, "R8 status wait alone grants nothing");
    swait = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_round_robin();
    t_levels();
    t_hold_release();
    t_idle_done();
    t_hurry();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule